// File: doc/BRIEF.md
# Register-Overlay Static RAM Bus Bridge

This block sits between a host that speaks an asynchronous static-RAM style bus (active-low chip enable, output enable and write enable, a 17-bit byte address and an 8-bit bidirectional data bus) and an external static RAM. The lowest 64 byte addresses are served by an on-chip register file. Every address from 0x40 upward is handed to the external RAM by forwarding the host strobes to the RAM control pins.

All host inputs, including the data bus, pass through a two-stage synchronizer on a fast system clock. Decoding and edge detection work on the synchronized copies. A write to a register is framed by the interval in which chip enable and write enable are both low. It commits when that interval closes, whichever strobe rises first, and it stores the data last seen while the interval was open. For an on-chip address all three external RAM strobes are held inactive, so the shadowed low part of the RAM neither drives the bus nor gets written.

Top module: `sram_overlay_bridge`

## Requirements
- R1: After a synchronous active-high reset, all 64 registers read 0x00, all three external strobes are high and the block does not drive the data bus.
- R2: Addresses 0x00000..0x0003F select register (address mod 64). A value written there is returned by a later read of the same address.
- R3: For addresses 0x00040..0x1FFFF the external chip enable, output enable and write enable follow the host chip enable, output enable and write enable respectively, and the block does not drive the data bus.
- R4: While an on-chip address is read, the external output enable stays high.
- R5: While an on-chip address is accessed, the external chip enable and write enable stay high.
- R6: A register write commits when the first of chip enable or write enable rises. The stored value is the bus value present while both were still low, and later bus changes are not stored.
- R7: Write enable low while chip enable is high writes nothing.
- R8: The block drives the data bus only during an on-chip read (chip enable and output enable low, write enable high). If write enable falls during such a read, the bus is released within 3 clock cycles.
- R9: A write to an external address leaves the register that has the same low 6 address bits unchanged.
- R10: An external strobe output reflects a change of the host inputs at the third rising clock edge after the change, and not at the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the host bus |
| rst | input | 1 | Synchronous active-high reset |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_addr | input | 17 | Host byte address |
| host_data | inout | 8 | Bidirectional host data bus |
| mem_ce_n | output | 1 | External RAM chip enable, active low, registered |
| mem_oe_n | output | 1 | External RAM output enable, active low, registered |
| mem_we_n | output | 1 | External RAM write enable, active low, registered |

## Verification
A corrupted decode shows up three edges after the address settles. It appears either as an external strobe going low for a register address or as the block driving the bus for an external one, so the bench checks both on every access in a sweep over all 64 registers and the range boundaries. A wrong write frame, such as committing on the wrong edge or latching stale data, stays hidden until the register is read back. For that reason every write is followed by a full readback against a model computed in the bench, including a write whose data changes mid-frame and a write enable pulse without chip enable. A bus driver left on after write enable falls is detected within three cycles by comparing the floating bus against the register contents.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int HOST_AW   = 17;
  localparam int HOST_DW   = 8;
  localparam int REG_WORDS = 64;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } strobe_t;
endpackage

// File: rtl/ovl_sync.sv
module ovl_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ovl_regfile.sv
module ovl_regfile #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int RAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [RAW-1:0] rd_addr,
  output logic [DW-1:0]  rd_q
);
  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
      rd_q <= '0;
    end else begin
      if (wr_en) words[wr_addr] <= wr_data;
      rd_q <= words[rd_addr];
    end
  end
endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl #(
  parameter int AW  = 17,
  parameter int DW  = 8,
  parameter int RAW = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce_s,
  input  logic           oe_s,
  input  logic           we_s,
  input  logic [AW-1:0]  addr_s,
  input  logic [DW-1:0]  data_s,
  output logic           mem_ce_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic           drive_en,
  output logic           wr_act,
  output logic           wr_commit,
  output logic           wr_en,
  output logic [RAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data
);
  localparam logic [AW-1:0] OVL_LIMIT = AW'(1) << RAW;

  logic           on_chip;
  logic           wr_prev;
  logic           lat_int;
  logic [RAW-1:0] lat_addr;
  logic [DW-1:0]  lat_data;

  assign on_chip = addr_s < OVL_LIMIT;
  assign wr_act  = ~ce_s & ~we_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev  <= 1'b0;
      lat_int  <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      drive_en <= 1'b0;
    end else begin
      wr_prev <= wr_act;
      if (wr_act) begin
        lat_addr <= addr_s[RAW-1:0];
        lat_data <= data_s;
        lat_int  <= on_chip;
      end
      mem_ce_n <= ce_s | on_chip;
      mem_oe_n <= oe_s | on_chip;
      mem_we_n <= we_s | on_chip;
      drive_en <= ~ce_s & ~oe_s & we_s & on_chip;
    end
  end

  assign wr_commit = wr_prev & ~wr_act;
  assign wr_en     = wr_commit & lat_int;
  assign wr_addr   = lat_addr;
  assign wr_data   = lat_data;
endmodule

// File: rtl/sram_overlay_bridge.sv
module sram_overlay_bridge
  import ovl_pkg::*;
#(
  parameter int AW    = HOST_AW,
  parameter int DW    = HOST_DW,
  parameter int WORDS = REG_WORDS,
  localparam int RAW  = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_ce_n,
  input  logic          host_oe_n,
  input  logic          host_we_n,
  input  logic [AW-1:0] host_addr,
  inout  wire  [DW-1:0] host_data,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n
);
  strobe_t        strb_raw, strb_s;
  logic [AW-1:0]  addr_s;
  logic [DW-1:0]  data_s;
  logic           drive_en, wr_act, wr_commit, wr_en;
  logic [RAW-1:0] wr_addr;
  logic [DW-1:0]  wr_data, rd_q;

  assign strb_raw = '{ce_n: host_ce_n, oe_n: host_oe_n, we_n: host_we_n};

  ovl_sync #(.W($bits(strobe_t)), .STAGES(2), .RST_VAL('1)) u_sync_strb (
    .clk(clk), .rst(rst), .d(strb_raw), .q(strb_s)
  );

  ovl_sync #(.W(AW + DW), .STAGES(2), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst), .d({host_addr, host_data}), .q({addr_s, data_s})
  );

  ovl_ctrl #(.AW(AW), .DW(DW), .RAW(RAW)) u_ctrl (
    .clk(clk), .rst(rst),
    .ce_s(strb_s.ce_n), .oe_s(strb_s.oe_n), .we_s(strb_s.we_n),
    .addr_s(addr_s), .data_s(data_s),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .drive_en(drive_en), .wr_act(wr_act), .wr_commit(wr_commit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  ovl_regfile #(.DEPTH(WORDS), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr_s[RAW-1:0]), .rd_q(rd_q)
  );

  assign host_data = drive_en ? rd_q : 'z;
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker (
  input logic clk,
  input logic rst,
  input logic drive_en,
  input logic wr_commit,
  input logic mem_ce_n,
  input logic mem_oe_n,
  input logic mem_we_n
);
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (mem_ce_n && mem_oe_n && mem_we_n && !drive_en));

  a_r4_oe_blocked: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> mem_oe_n);

  a_r5_ce_we_blocked: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> (mem_ce_n && mem_we_n));

  a_r8_no_drive_in_ext_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !drive_en);

  a_r6_commit_single: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);
endmodule

bind sram_overlay_bridge ovl_checker u_chk (
  .clk(clk), .rst(rst), .drive_en(drive_en), .wr_commit(wr_commit),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
);

// File: tb/sram_overlay_bridge_bench.sv
module sram_overlay_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  tb_val = '0;
  logic        tb_drv = 1'b0;
  wire  [7:0]  data;
  logic        mce, moe, mwe;
  logic [7:0]  model [64];
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign data = tb_drv ? tb_val : 'z;

  sram_overlay_bridge u_sram_overlay_bridge (
    .clk(clk), .rst(rst), .host_ce_n(ce_n), .host_oe_n(oe_n), .host_we_n(we_n),
    .host_addr(addr), .host_data(data),
    .mem_ce_n(mce), .mem_oe_n(moe), .mem_we_n(mwe)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; tb_drv = 1'b0;
  endtask

  // ce_first=1: chip enable rises first, else write enable
  task automatic wr_reg(input logic [16:0] a, input logic [7:0] v, input bit ce_first);
    addr = a; tb_val = v; tb_drv = 1'b1; ce_n = 1'b0; we_n = 1'b1;
    cyc(3);
    we_n = 1'b0;
    cyc(4);
    if (ce_first) ce_n = 1'b1; else we_n = 1'b1;
    cyc(4);
    idle();
    cyc(4);
  endtask

  task automatic rd_reg(input logic [16:0] a, input logic [7:0] exp, input string req);
    addr = a; tb_drv = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    cyc(5);
    chk(data === exp, req, int'(data), int'(exp));
    chk(moe === 1'b1, "R4", int'(moe), 1);
    chk(mce === 1'b1 && mwe === 1'b1, "R5", int'({mce, mwe}), 3);
    idle();
    cyc(4);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    cyc(4);
    rst = 1'b0;
    cyc(1);
    chk(mce && moe && mwe, "R1", int'({mce, moe, mwe}), 7);

    // R1: every register reads zero after reset
    for (int a = 0; a < 64; a++) rd_reg(17'(a), 8'h00, "R1");

    // R2, R6: write every register, alternating which strobe ends the frame
    for (int a = 0; a < 64; a++) begin
      model[a] = 8'((a * 37 + 5) & 8'hFF) | 8'h01;
      wr_reg(17'(a), model[a], a[0]);
    end
    for (int a = 0; a < 64; a++) rd_reg(17'(a), model[a], "R2");

    // R6: data changing inside the frame; last value stored, later value ignored
    addr = 17'd3; tb_drv = 1'b1; tb_val = 8'hA1; ce_n = 1'b0; we_n = 1'b0;
    cyc(4);
    tb_val = 8'hB2;
    cyc(4);
    we_n = 1'b1;
    cyc(4);
    tb_val = 8'hC3;
    cyc(4);
    idle(); cyc(4);
    model[3] = 8'hB2;
    rd_reg(17'd3, model[3], "R6");

    // R7: write enable without chip enable
    addr = 17'd7; tb_drv = 1'b1; tb_val = 8'h99; ce_n = 1'b1; we_n = 1'b0;
    cyc(6);
    idle(); cyc(4);
    rd_reg(17'd7, model[7], "R7");

    // R3, R9, R10: external range accesses, boundary 0x40 and the top
    foreach (model[k]) if (k < 4) begin
      logic [16:0] ea;
      ea = (k == 0) ? 17'h00040 : (k == 1) ? 17'h00041 : (k == 2) ? 17'h1FFFF : 17'h10005;
      addr = ea; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; tb_drv = 1'b0;
      cyc(2);
      chk(mce === 1'b1 && moe === 1'b1, "R10", int'({mce, moe}), 3);
      cyc(1);
      chk(mce === 1'b0 && moe === 1'b0 && mwe === 1'b1, "R10", int'({mce, moe, mwe}), 1);
      cyc(2);
      chk(data !== model[ea[5:0]], "R3", int'(data), int'(model[ea[5:0]]));
      oe_n = 1'b1; tb_drv = 1'b1; tb_val = 8'h5A; we_n = 1'b0;
      cyc(4);
      chk(mce === 1'b0 && moe === 1'b1 && mwe === 1'b0, "R3", int'({mce, moe, mwe}), 2);
      idle();
      cyc(4);
      chk(mce && moe && mwe, "R3", int'({mce, moe, mwe}), 7);
      rd_reg({11'd0, ea[5:0]}, model[ea[5:0]], "R9");
    end

    // R8: write enable falls while the block drives a read
    addr = 17'd5; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; tb_drv = 1'b0;
    cyc(5);
    chk(data === model[5], "R8", int'(data), int'(model[5]));
    we_n = 1'b0;
    cyc(3);
    chk(data !== model[5], "R8", int'(data), int'(model[5]));
    tb_drv = 1'b1; tb_val = 8'h77;
    cyc(4);
    we_n = 1'b1;
    cyc(4);
    idle(); cyc(4);
    model[5] = 8'h77;
    rd_reg(17'd5, model[5], "R6");

    // R2: boundary registers once more
    rd_reg(17'h0003F, model[63], "R2");
    rd_reg(17'h00000, model[0], "R2");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule